// File: doc/BRIEF.md
# Glyph Row Expander Writer

This block turns one-bit-per-pixel character bitmaps into colour pixels for a byte-per-pixel frame buffer. Software hands it 32-bit words; each word carries two 16-pixel glyph rows, the upper half being the first row. For every row the block computes a frame-buffer address from a start position it holds plus a running row counter. It then emits one pixel write per clock, leftmost pixel first, on a simple RAM write port.

The block keeps track of how far the current character cell has been drawn. When the row counter reaches the cell height, the start position moves right by the cell width, so that consecutive characters land side by side. Any rest of the current word is then dropped. A start-of-glyph write clears the row counter and a continue write carries on from where it stopped. A transparency mode leaves the pixels under zero bits untouched, so text can be laid over an existing picture. Rows that would fall outside the buffer are not drawn at all, but they still count as rows.

Top module: `glyph_row_expander`

## Requirements
- R1: Within one 16-bit row, bit 15 is written to address (start y + row counter) × BUF_W + start x and bit 0 to that address + 15. The pixels are issued one per clock in rising address order.
- R2: A word is drawn as bits 31:16 first and bits 15:0 second. The row counter increases by one after each half. Each half that is processed takes exactly 16 busy cycles.
- R3: A word written with wr_restart = 1 clears the row counter before its first row. A word written with wr_restart = 0 keeps the counter value.
- R4: When the row counter, after an increment, equals the cell height (cell_size[15:0]), start x increases by the cell width (cell_size[31:16]). The unprocessed half of the word is then discarded and the block returns to ready.
- R5: A one bit writes fg_color when op_word[1] is 1 and bg_color when op_word[1] is 0.
- R6: A zero bit writes bg_color when op_word[29] is 0. When op_word[29] is 1, a zero bit produces no write.
- R7: A row produces no writes in three cases: start x ≥ BUF_W, row y ≥ BUF_H, or row offset + 16 ≥ BUF_W × BUF_H. The row counter still advances for such a row.
- R8: wr_ready is low for every cycle in which a word is being expanded. A word is taken only on a clock edge where wr_valid and wr_ready are both high. Words or restarts offered while wr_ready is low have no effect.
- R9: pos_load copies pos_x_in and pos_y_in into the start position on a clock edge where the block is ready. A pos_load while busy is ignored.
- R10: After reset, wr_ready is 1, the row counter and the start position are 0, and pix_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Glyph word offered |
| wr_restart | input | 1 | 1: start-of-glyph word (clears row counter); 0: continue word |
| wr_data | input | 32 | Two glyph rows, upper half first |
| wr_ready | output | 1 | High when a new word can be taken |
| pos_load | input | 1 | Load the start position |
| pos_x_in | input | 16 | Start x to load |
| pos_y_in | input | 16 | Start y to load |
| pos_x | output | 16 | Current start x |
| pos_y | output | 16 | Current start y |
| cell_size | input | 32 | Cell width in 31:16, cell height in 15:0 |
| fg_color | input | 8 | Foreground colour |
| bg_color | input | 8 | Background colour |
| op_word | input | 32 | Operation word: bit 1 selects foreground for one bits, bit 29 makes zero bits transparent |
| row_count | output | 16 | Current row counter |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | 11 | Pixel address (log2 of BUF_W × BUF_H) |
| pix_data | output | 8 | Pixel colour |

## Verification
The bench targets three kinds of corner case. The first is the cell that completes after the upper half: a design that ignored the discard would write a stray row and hold wr_ready low 16 cycles too long. The second is the buffer-edge rows. A row that ends exactly on the last pixel must be skipped; one that ends a pixel earlier must be drawn; and a row whose lower neighbour leaves the buffer must be drawn. A wrong inequality either shows up as extra writes or as lost pixels. The third is the interplay of continue words with the counter and of transparency with zero bits: a design that cleared the counter on every word would never advance x, and one that wrote zero bits in transparent mode would paint the background over existing pixels. Restarts and position loads offered while busy are checked for having no effect on the counter, the position or the write count.

// File: rtl/gre_pkg.sv
package gre_pkg;

    // Architectural constants fixed by the word format: 16-pixel rows, 16-bit coordinates.
    localparam int COORD_W = 16;
    localparam int ROW_PIX = 16;
    localparam int COL_W   = $clog2(ROW_PIX);
    localparam int WORD_W  = 2 * ROW_PIX;

    // Registered state of the expansion sequencer.
    typedef struct packed {
        logic               busy;
        logic               half;   // 0: bits 31:16, 1: bits 15:0
        logic [COL_W-1:0]   col;
        logic [WORD_W-1:0]  word;
        logic [COORD_W-1:0] row;
        logic [COORD_W-1:0] px;
        logic [COORD_W-1:0] py;
    } seq_t;

endpackage

// File: rtl/gre_seq.sv
module gre_seq
    import gre_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic               wr_restart,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               pos_load,
    input  logic [COORD_W-1:0] load_x,
    input  logic [COORD_W-1:0] load_y,
    input  logic [COORD_W-1:0] cell_w,
    input  logic [COORD_W-1:0] cell_h,
    output logic               busy,
    output logic               cur_bit,
    output logic [COL_W-1:0]   col,
    output logic [COORD_W-1:0] row,
    output logic [COORD_W-1:0] px,
    output logic [COORD_W-1:0] py
);

    localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_PIX - 1);

    seq_t q, d;
    logic [ROW_PIX-1:0] half_bits;
    logic [COORD_W-1:0] row_inc;

    assign half_bits = q.half ? q.word[ROW_PIX-1:0] : q.word[WORD_W-1:ROW_PIX];
    assign row_inc   = q.row + COORD_W'(1);

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (pos_load) begin
                d.px = load_x;
                d.py = load_y;
            end
            if (wr_valid) begin
                d.busy = 1'b1;
                d.half = 1'b0;
                d.col  = '0;
                d.word = wr_data;
                if (wr_restart) begin
                    d.row = '0;
                end
            end
        end else if (q.col == COL_LAST) begin
            d.row = row_inc;
            d.col = '0;
            if (row_inc == cell_h) begin
                d.px   = q.px + cell_w;
                d.busy = 1'b0;
            end else if (q.half) begin
                d.busy = 1'b0;
            end else begin
                d.half = 1'b1;
            end
        end else begin
            d.col = q.col + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign cur_bit = half_bits[COL_LAST - q.col];
    assign col     = q.col;
    assign row     = q.row;
    assign px      = q.px;
    assign py      = q.py;

    // R3: a start-of-glyph word begins with the counter at zero
    a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && wr_valid && wr_restart) |=> (q.row == '0));

    // R2: the counter steps by exactly one at the end of every half
    a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.col == COL_LAST) |=> (q.row == COORD_W'($past(q.row) + 1'b1)));

    // R2: a half is never cut short before its sixteenth pixel
    a_r2_half_length: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.col != COL_LAST) |=> q.busy);

    // R4: reaching the cell height moves x by the cell width and ends the word
    a_r4_cell_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.col == COL_LAST && row_inc == cell_h)
        |=> (!q.busy && q.px == COORD_W'($past(q.px) + $past(cell_w))));

    // R9: the start y cannot move while a word is being expanded
    a_r9_pos_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> (q.py == $past(q.py)));

endmodule

// File: rtl/gre_row_window.sv
module gre_row_window
    import gre_pkg::*;
#(
    parameter int BUF_W  = 64,
    parameter int BUF_H  = 32,
    parameter int ADDR_W = $clog2(BUF_W * BUF_H)
) (
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] row,
    output logic [ADDR_W-1:0]  base,
    output logic               row_ok
);

    localparam int OFF_W    = 2 * COORD_W + 2;
    localparam int BUF_SIZE = BUF_W * BUF_H;

    logic [COORD_W:0]   y_abs;
    logic [OFF_W-1:0]   y_term;
    logic [OFF_W-1:0]   offset;

    assign y_abs = {1'b0, org_y} + {1'b0, row};

    generate
        if ((BUF_W & (BUF_W - 1)) == 0) begin : g_pow2
            assign y_term = OFF_W'(y_abs) << $clog2(BUF_W);
        end else begin : g_mult
            assign y_term = OFF_W'(y_abs) * OFF_W'(BUF_W);
        end
    endgenerate

    assign offset = y_term + OFF_W'(org_x);
    assign base   = offset[ADDR_W-1:0];
    assign row_ok = (OFF_W'(org_x) < OFF_W'(BUF_W))
                 && (OFF_W'(y_abs) < OFF_W'(BUF_H))
                 && ((offset + OFF_W'(ROW_PIX)) < OFF_W'(BUF_SIZE));

endmodule

// File: rtl/gre_pixel_shader.sv
module gre_pixel_shader #(
    parameter int PIX_W = 8
) (
    input  logic             active,
    input  logic             row_ok,
    input  logic             bit_val,
    input  logic             fg_sel,
    input  logic             keep_zero,
    input  logic [PIX_W-1:0] fg,
    input  logic [PIX_W-1:0] bg,
    output logic             we,
    output logic [PIX_W-1:0] data
);

    always_comb begin
        we   = active && row_ok && (bit_val || !keep_zero);
        data = (bit_val && fg_sel) ? fg : bg;
    end

endmodule

// File: rtl/glyph_row_expander.sv
module glyph_row_expander
    import gre_pkg::*;
#(
    parameter int BUF_W = 64,
    parameter int BUF_H = 32,
    parameter int PIX_W = 8,
    localparam int ADDR_W = $clog2(BUF_W * BUF_H)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic               wr_restart,
    input  logic [WORD_W-1:0]  wr_data,
    output logic               wr_ready,
    input  logic               pos_load,
    input  logic [COORD_W-1:0] pos_x_in,
    input  logic [COORD_W-1:0] pos_y_in,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    input  logic [31:0]        cell_size,
    input  logic [PIX_W-1:0]   fg_color,
    input  logic [PIX_W-1:0]   bg_color,
    input  logic [31:0]        op_word,
    output logic [COORD_W-1:0] row_count,
    output logic               pix_we,
    output logic [ADDR_W-1:0]  pix_addr,
    output logic [PIX_W-1:0]   pix_data
);

    logic               busy;
    logic               cur_bit;
    logic [COL_W-1:0]   col;
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] px;
    logic [COORD_W-1:0] py;
    logic [ADDR_W-1:0]  base;
    logic               row_ok;
    logic               unused_op_bits;

    assign unused_op_bits = ^{op_word[31:30], op_word[28:2], op_word[0]};

    gre_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_restart (wr_restart),
        .wr_data    (wr_data),
        .pos_load   (pos_load),
        .load_x     (pos_x_in),
        .load_y     (pos_y_in),
        .cell_w     (cell_size[31:16]),
        .cell_h     (cell_size[15:0]),
        .busy       (busy),
        .cur_bit    (cur_bit),
        .col        (col),
        .row        (row),
        .px         (px),
        .py         (py)
    );

    gre_row_window #(
        .BUF_W  (BUF_W),
        .BUF_H  (BUF_H),
        .ADDR_W (ADDR_W)
    ) u_window (
        .org_x  (px),
        .org_y  (py),
        .row    (row),
        .base   (base),
        .row_ok (row_ok)
    );

    gre_pixel_shader #(
        .PIX_W (PIX_W)
    ) u_shader (
        .active    (busy),
        .row_ok    (row_ok),
        .bit_val   (cur_bit),
        .fg_sel    (op_word[1]),
        .keep_zero (op_word[29]),
        .fg        (fg_color),
        .bg        (bg_color),
        .we        (pix_we),
        .data      (pix_data)
    );

    assign wr_ready  = !busy;
    assign pos_x     = px;
    assign pos_y     = py;
    assign row_count = row;
    assign pix_addr  = base + ADDR_W'(col);

    // R8: no pixel is written while the block advertises itself as ready
    a_r8_no_write_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> !wr_ready);

    // R1: within a row the address climbs by one per cycle
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && col != COL_W'(ROW_PIX - 1))
        |=> (pix_addr == ADDR_W'($past(pix_addr) + 1'b1)));

    // R6: with transparency and foreground selected, every write is foreground
    a_r6_transparent_fg: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_we && op_word[29] && op_word[1]) |-> (pix_data == fg_color));

endmodule

// File: tb/glyph_row_expander_tb_top.sv
module glyph_row_expander_tb_top;

    localparam int BW   = 64;
    localparam int BH   = 32;
    localparam int SIZE = BW * BH;
    localparam logic [7:0] FG = 8'hA5;
    localparam logic [7:0] BG = 8'h3C;

    typedef struct packed {
        logic        restart;
        logic        transp;
        logic        fgsel;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] cw;
        logic [15:0] ch;
        logic [31:0] data;
        logic [7:0]  exp_we;
        logic [15:0] exp_row;
        logic [15:0] exp_x;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 16'd0,  16'd0,  16'd8,  16'd4, 32'h8001_FFFF, 8'd32, 16'd2, 16'd0},
        '{1'b0, 1'b1, 1'b1, 16'd0,  16'd0,  16'd8,  16'd4, 32'hF0F0_0F0F, 8'd16, 16'd4, 16'd8},
        '{1'b1, 1'b0, 1'b0, 16'd16, 16'd4,  16'd10, 16'd1, 32'hAAAA_5555, 8'd16, 16'd1, 16'd26},
        '{1'b0, 1'b1, 1'b1, 16'd26, 16'd4,  16'd10, 16'd1, 32'h0000_0001, 8'd1,  16'd3, 16'd26},
        '{1'b1, 1'b0, 1'b1, 16'd64, 16'd0,  16'd4,  16'd5, 32'hFFFF_FFFF, 8'd0,  16'd2, 16'd64},
        '{1'b1, 1'b0, 1'b1, 16'd0,  16'd32, 16'd4,  16'd5, 32'hFFFF_FFFF, 8'd0,  16'd2, 16'd0},
        '{1'b1, 1'b0, 1'b1, 16'd48, 16'd31, 16'd4,  16'd5, 32'hFFFF_FFFF, 8'd0,  16'd2, 16'd48},
        '{1'b1, 1'b0, 1'b1, 16'd47, 16'd31, 16'd4,  16'd5, 32'hFFFF_0000, 8'd16, 16'd2, 16'd47},
        '{1'b1, 1'b1, 1'b1, 16'd0,  16'd30, 16'd4,  16'd3, 32'h0001_8000, 8'd2,  16'd2, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_restart = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        pos_load = 1'b0;
    logic [15:0] pos_x_in = '0;
    logic [15:0] pos_y_in = '0;
    logic [15:0] pos_x;
    logic [15:0] pos_y;
    logic [31:0] cell_size = '0;
    logic [31:0] op_word = '0;
    logic [15:0] row_count;
    logic        pix_we;
    logic [10:0] pix_addr;
    logic [7:0]  pix_data;

    int checks = 0;
    int fails  = 0;
    int we_total = 0;
    bit finished = 1'b0;

    logic [7:0] cap_mem   [SIZE];
    logic [7:0] model_mem [SIZE];
    logic [15:0] m_px, m_py, m_row;

    always #10 clk = ~clk;   // 50 MHz

    glyph_row_expander dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_restart (wr_restart),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .pos_load   (pos_load),
        .pos_x_in   (pos_x_in),
        .pos_y_in   (pos_y_in),
        .pos_x      (pos_x),
        .pos_y      (pos_y),
        .cell_size  (cell_size),
        .fg_color   (FG),
        .bg_color   (BG),
        .op_word    (op_word),
        .row_count  (row_count),
        .pix_we     (pix_we),
        .pix_addr   (pix_addr),
        .pix_data   (pix_data)
    );

    // Pixel RAM stand-in: records writes half a cycle away from the active edge.
    always @(negedge clk) begin
        if (pix_we) begin
            cap_mem[pix_addr] = pix_data;
            we_total = we_total + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic load_pos(input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        pos_load = 1'b1; pos_x_in = x; pos_y_in = y;
        @(negedge clk);
        pos_load = 1'b0;
        m_px = x; m_py = y;
    endtask

    task automatic send_word(input logic rs, input logic [31:0] d, output int cyc);
        @(negedge clk);
        wr_valid = 1'b1; wr_restart = rs; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        cyc = 0;
        while (!wr_ready) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    // Reference drawn from the requirements: rows, colours, skipping, cell advance.
    task automatic model_word(input logic rs, input logic tr, input logic fs,
                              input logic [15:0] cw, input logic [15:0] ch,
                              input logic [31:0] d, output int writes, output int halves);
        writes = 0; halves = 0;
        if (rs) m_row = '0;
        for (int h = 0; h < 2; h++) begin
            logic [15:0] bits;
            int y, off;
            bits = (h == 0) ? d[31:16] : d[15:0];
            y = int'(m_py) + int'(m_row);
            off = y * BW + int'(m_px);
            halves++;
            if (!(int'(m_px) >= BW || y >= BH || off + 16 >= SIZE)) begin
                for (int i = 0; i < 16; i++) begin
                    if (bits[15 - i]) begin
                        model_mem[off + i] = fs ? FG : BG;
                        writes++;
                    end else if (!tr) begin
                        model_mem[off + i] = BG;
                        writes++;
                    end
                end
            end
            m_row = m_row + 16'd1;
            if (m_row == ch) begin
                m_px = m_px + cw;
                break;
            end
        end
    endtask

    task automatic compare_mem(input string what);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < SIZE; a++) begin
            if (cap_mem[a] !== model_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        chk(bad == 0, what, (first < 0) ? 0 : cap_mem[first], (first < 0) ? 0 : model_mem[first]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int cyc, mw, mh, w0;
        for (int a = 0; a < SIZE; a++) begin
            cap_mem[a] = 8'h00;
            model_mem[a] = 8'h00;
        end
        m_px = '0; m_py = '0; m_row = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(wr_ready == 1'b1, "R10 ready after reset", wr_ready, 1);
        chk(row_count == 16'd0 && pos_x == 16'd0 && pos_y == 16'd0,
            "R10 counter and position after reset", {row_count, pos_x, pos_y}, 0);
        chk(pix_we == 1'b0, "R10 no write in reset", pix_we, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of stimulus and expected results
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            cell_size = {t.cw, t.ch};
            op_word = {2'b00, t.transp, 27'd0, t.fgsel, 1'b0};
            load_pos(t.x, t.y);
            // R9: position load while idle
            chk(pos_x == t.x && pos_y == t.y, "R9 idle position load", {pos_x, pos_y}, {t.x, t.y});
            model_word(t.restart, t.transp, t.fgsel, t.cw, t.ch, t.data, mw, mh);
            w0 = we_total;
            send_word(t.restart, t.data, cyc);
            chk(we_total - w0 == int'(t.exp_we) && mw == int'(t.exp_we),
                "R5 R6 R7 write count", we_total - w0, t.exp_we);
            compare_mem("R1 R5 R6 pixel image");
            chk(row_count == t.exp_row, "R2 R3 row counter", row_count, t.exp_row);
            chk(pos_x == t.exp_x && m_px == t.exp_x, "R4 start x", pos_x, t.exp_x);
            chk(cyc == 16 * mh, "R2 R4 R8 busy cycles", cyc, 16 * mh);
        end

        // R8 and R9: restarts and loads offered while busy have no effect
        cell_size = {16'd4, 16'd256};
        op_word = 32'h0000_0002;
        load_pos(16'd0, 16'd8);
        m_row = '0;
        model_word(1'b1, 1'b0, 1'b1, 16'd4, 16'd256, 32'hFFFF_FFFF, mw, mh);
        w0 = we_total;
        @(negedge clk);
        wr_valid = 1'b1; wr_restart = 1'b1; wr_data = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        wr_data = 32'h0000_0000;
        pos_load = 1'b1; pos_x_in = 16'd5; pos_y_in = 16'd5;
        repeat (5) @(negedge clk);
        wr_valid = 1'b0; pos_load = 1'b0;
        while (!wr_ready) @(negedge clk);
        chk(row_count == 16'd2, "R8 restart while busy ignored", row_count, 2);
        chk(we_total - w0 == 32, "R8 second word not taken while busy", we_total - w0, 32);
        chk(pos_x == 16'd0 && pos_y == 16'd8, "R9 load while busy ignored", {pos_x, pos_y}, {16'd0, 16'd8});
        compare_mem("R1 image after busy-time stimulus");

        // R3: continue word after that keeps counting from 2
        model_word(1'b0, 1'b0, 1'b1, 16'd4, 16'd256, 32'h1234_8765, mw, mh);
        w0 = we_total;
        send_word(1'b0, 32'h1234_8765, cyc);
        chk(row_count == 16'd4, "R3 continue keeps counter", row_count, 4);
        compare_mem("R1 R2 rows 2 and 3");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule